// File: doc/BRIEF.md
# Nibble-Command Register Access Slave

This block sits on the device side of a byte-wide host link and turns a stream of command bytes into accesses to an 8-bit register file. The upper four bits of each command byte select an operation. The lower four bits carry a payload nibble. An 8-bit register address is built from two address commands, one for each half. A data byte is built from a low-data command followed by a high-data command. The write takes place when the high-data command arrives.

Read commands return the byte at the current address on a separate output byte stream. A second form of the read command also advances the address once the byte has been taken. A host can therefore pull a multi-byte block, such as a pair of 24-bit positions sent low byte first, by issuing that command once per byte.

The address also advances after every committed write. Several data bytes sent after one address therefore land in consecutive registers. The register file itself lives outside the block: the block presents an address, samples the read data the file returns, and issues a one-cycle write strobe with address and data.

Top module: `nibreg_slave`

## Requirements
- R1: While reset is asserted, `cmd_ready`, `wr_stb` and `ret_valid` are low and `reg_sel` is 0x00. After release, `cmd_ready` goes high and the held low-data nibble is zero, so a high-data command with payload P writes byte {P,0}.
- R2: A command with opcode 0x0 (bits [7:4]) replaces bits [3:0] of the address with its payload and leaves bits [7:4] unchanged.
- R3: A command with opcode 0x1 replaces bits [7:4] of the address with its payload and leaves bits [3:0] unchanged.
- R4: A command with opcode 0x2 stores its payload as the held low-data nibble and produces no write strobe.
- R5: A command with opcode 0x3 and payload P raises `wr_stb` in the cycle after it is accepted, for exactly that one cycle. In that cycle `wr_sel` is the address current when the command was accepted and `wr_byte` is {P, held nibble}.
- R6: After each committed write the address advances by one, wrapping from 0xFF to 0x00. Back-to-back data pairs therefore write consecutive registers.
- R7: A command with opcode 0x4 raises `ret_valid` in the cycle after acceptance, with `ret_byte` equal to `reg_rdata` for the current address. The address is left unchanged.
- R8: A command with opcode 0x5 returns the byte as in R7 and then advances the address by one. N such commands return N consecutive registers in ascending order.
- R9: Commands with opcodes 0x6 to 0xF cause no write strobe and no returned byte, and leave the address unchanged.
- R10: While `cmd_valid` is low, `cmd_byte` has no effect on the address, the strobe or the return stream.
- R11: The held low-data nibble survives a committed write. A further high-data command with no low-data command in between reuses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Block accepts commands (high out of reset) |
| cmd_byte | input | 8 | Opcode in [7:4], payload nibble in [3:0] |
| reg_sel | output | 8 | Current register address presented to the register file |
| reg_rdata | input | 8 | Register file contents at `reg_sel` |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_sel | output | 8 | Write address, valid with `wr_stb` |
| wr_byte | output | 8 | Write data, valid with `wr_stb` |
| ret_valid | output | 1 | Returned byte present, one cycle per read command |
| ret_byte | output | 8 | Returned register byte |

## Verification
Every result is registered once. The write strobe, the returned byte and the new address all appear after the clock edge that accepts the command, so each is due exactly one cycle after acceptance. The bench drives each command on a falling edge and lets the next rising edge accept it. The monitor samples on the following falling edge and pops the queued expectation in that same half-cycle. An output arriving a cycle early or late is therefore an unexpected strobe or a mismatch against the wrong queue entry. Address checks are made only after the command stream has gone idle, so `reg_sel` is compared once it has settled.

// File: rtl/nibreg_pkg.sv
package nibreg_pkg;

  localparam int NIB_W_DFLT = 4;

  typedef enum logic [3:0] {
    OPC_ADDR_LO = 4'h0,
    OPC_ADDR_HI = 4'h1,
    OPC_DATA_LO = 4'h2,
    OPC_DATA_HI = 4'h3,
    OPC_READ    = 4'h4,
    OPC_READ_NX = 4'h5
  } opc_e;

endpackage

// File: rtl/nibreg_decode.sv
module nibreg_decode #(
  parameter int NIB_W = nibreg_pkg::NIB_W_DFLT
) (
  input  logic               cmd_valid,
  input  logic               cmd_ready,
  input  logic [2*NIB_W-1:0] cmd_byte,
  output logic               fire,
  output logic               is_alo,
  output logic               is_ahi,
  output logic               is_dlo,
  output logic               is_dhi,
  output logic               is_rd,
  output logic               is_rdn,
  output logic [NIB_W-1:0]   payload
);
  import nibreg_pkg::*;

  localparam int BYTE_W = 2 * NIB_W;

  function automatic logic [NIB_W-1:0] opc_field(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:NIB_W];
  endfunction

  function automatic logic [NIB_W-1:0] pay_field(input logic [BYTE_W-1:0] b);
    return b[NIB_W-1:0];
  endfunction

  logic [NIB_W-1:0] opc;

  assign fire    = cmd_valid & cmd_ready;
  assign opc     = opc_field(cmd_byte);
  assign payload = pay_field(cmd_byte);

  always_comb begin
    is_alo = 1'b0;
    is_ahi = 1'b0;
    is_dlo = 1'b0;
    is_dhi = 1'b0;
    is_rd  = 1'b0;
    is_rdn = 1'b0;
    if (fire) begin
      if (opc == NIB_W'(OPC_ADDR_LO)) is_alo = 1'b1;
      if (opc == NIB_W'(OPC_ADDR_HI)) is_ahi = 1'b1;
      if (opc == NIB_W'(OPC_DATA_LO)) is_dlo = 1'b1;
      if (opc == NIB_W'(OPC_DATA_HI)) is_dhi = 1'b1;
      if (opc == NIB_W'(OPC_READ))    is_rd  = 1'b1;
      if (opc == NIB_W'(OPC_READ_NX)) is_rdn = 1'b1;
    end
  end

endmodule

// File: rtl/nibreg_ptr.sv
module nibreg_ptr #(
  parameter int NIB_W = nibreg_pkg::NIB_W_DFLT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_lo,
  input  logic               ld_hi,
  input  logic               bump,
  input  logic [NIB_W-1:0]   nib,
  output logic [2*NIB_W-1:0] ptr
);
  localparam int LANES = 2;
  localparam int W     = LANES * NIB_W;

  function automatic logic [W-1:0] step(input logic [W-1:0] a);
    return W'(a + 1'b1);
  endfunction

  logic [W-1:0]     ptr_q;
  logic [W-1:0]     base;
  logic [W-1:0]     ptr_d;
  logic [LANES-1:0] lane_ld;

  assign lane_ld = {ld_hi, ld_lo};
  assign base    = bump ? step(ptr_q) : ptr_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ptr_d[g*NIB_W +: NIB_W] = lane_ld[g] ? nib : base[g*NIB_W +: NIB_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/nibreg_wpath.sv
module nibreg_wpath #(
  parameter int NIB_W = nibreg_pkg::NIB_W_DFLT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_lo,
  input  logic               commit,
  input  logic [NIB_W-1:0]   nib,
  input  logic [2*NIB_W-1:0] addr,
  output logic               wr_stb,
  output logic [2*NIB_W-1:0] wr_sel,
  output logic [2*NIB_W-1:0] wr_byte
);
  localparam int W = 2 * NIB_W;

  function automatic logic [W-1:0] join_nib(input logic [NIB_W-1:0] hi,
                                            input logic [NIB_W-1:0] lo);
    return {hi, lo};
  endfunction

  logic [NIB_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (ld_lo) hold_q <= nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_sel  <= '0;
      wr_byte <= '0;
    end else begin
      wr_stb <= commit;
      if (commit) begin
        wr_sel  <= addr;
        wr_byte <= join_nib(nib, hold_q);
      end
    end
  end

endmodule

// File: rtl/nibreg_rdret.sv
module nibreg_rdret #(
  parameter int NIB_W = nibreg_pkg::NIB_W_DFLT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [2*NIB_W-1:0] rdata,
  output logic               ret_valid,
  output logic [2*NIB_W-1:0] ret_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_valid <= 1'b0;
      ret_byte  <= '0;
    end else begin
      ret_valid <= take;
      if (take) ret_byte <= rdata;
    end
  end

endmodule

// File: rtl/nibreg_slave.sv
module nibreg_slave #(
  parameter int NIB_W = nibreg_pkg::NIB_W_DFLT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2*NIB_W-1:0] cmd_byte,
  output logic [2*NIB_W-1:0] reg_sel,
  input  logic [2*NIB_W-1:0] reg_rdata,
  output logic               wr_stb,
  output logic [2*NIB_W-1:0] wr_sel,
  output logic [2*NIB_W-1:0] wr_byte,
  output logic               ret_valid,
  output logic [2*NIB_W-1:0] ret_byte
);
  logic             rdy_q;
  logic             evt_fire;
  logic             evt_alo;
  logic             evt_ahi;
  logic             evt_dlo;
  logic             evt_commit;
  logic             evt_read;
  logic             evt_readnx;
  logic             evt_take;
  logic             evt_bump;
  logic [NIB_W-1:0] pay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign cmd_ready = rdy_q;

  nibreg_decode #(.NIB_W(NIB_W)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_ready (rdy_q),
    .cmd_byte  (cmd_byte),
    .fire      (evt_fire),
    .is_alo    (evt_alo),
    .is_ahi    (evt_ahi),
    .is_dlo    (evt_dlo),
    .is_dhi    (evt_commit),
    .is_rd     (evt_read),
    .is_rdn    (evt_readnx),
    .payload   (pay)
  );

  assign evt_take = evt_read | evt_readnx;
  assign evt_bump = evt_commit | evt_readnx;

  nibreg_ptr #(.NIB_W(NIB_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lo (evt_alo),
    .ld_hi (evt_ahi),
    .bump  (evt_bump),
    .nib   (pay),
    .ptr   (reg_sel)
  );

  nibreg_wpath #(.NIB_W(NIB_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_lo   (evt_dlo),
    .commit  (evt_commit),
    .nib     (pay),
    .addr    (reg_sel),
    .wr_stb  (wr_stb),
    .wr_sel  (wr_sel),
    .wr_byte (wr_byte)
  );

  nibreg_rdret #(.NIB_W(NIB_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (evt_take),
    .rdata     (reg_rdata),
    .ret_valid (ret_valid),
    .ret_byte  (ret_byte)
  );

endmodule

// File: rtl/nibreg_chk.sv
module nibreg_chk #(
  parameter int NIB_W = nibreg_pkg::NIB_W_DFLT
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [2*NIB_W-1:0] cmd_byte,
  input logic [2*NIB_W-1:0] reg_sel,
  input logic               wr_stb,
  input logic [2*NIB_W-1:0] wr_byte,
  input logic               ret_valid
);
  localparam int W = 2 * NIB_W;

  logic             acc;
  logic [NIB_W-1:0] opc;

  assign acc = cmd_valid & cmd_ready;
  assign opc = cmd_byte[W-1:NIB_W];

  assert_ready_low_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !cmd_ready && !wr_stb && !ret_valid);

  assert_strobe_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(acc && opc == NIB_W'(3)));

  assert_strobe_hi_nib_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> wr_byte[W-1:NIB_W] == $past(cmd_byte[NIB_W-1:0]));

  assert_write_bumps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && opc == NIB_W'(3)) |=> reg_sel == W'($past(reg_sel) + 1'b1));

  assert_return_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> $past(acc && (opc == NIB_W'(4) || opc == NIB_W'(5))));

  assert_read_keeps_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && opc == NIB_W'(4)) |=> $stable(reg_sel));

  assert_readnx_bumps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && opc == NIB_W'(5)) |=> reg_sel == W'($past(reg_sel) + 1'b1));

  assert_unknown_opc_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && opc > NIB_W'(5)) |=> !wr_stb && !ret_valid && $stable(reg_sel));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> !wr_stb && !ret_valid && $stable(reg_sel));

endmodule

bind nibreg_slave nibreg_chk #(.NIB_W(NIB_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_byte  (cmd_byte),
  .reg_sel   (reg_sel),
  .wr_stb    (wr_stb),
  .wr_byte   (wr_byte),
  .ret_valid (ret_valid)
);

// File: tb/sim_nibreg_slave.sv
module sim_nibreg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] reg_sel;
  logic [7:0] reg_rdata;
  logic       wr_stb;
  logic [7:0] wr_sel;
  logic [7:0] wr_byte;
  logic       ret_valid;
  logic [7:0] ret_byte;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] regs [256];   // register file seen by the design
  logic [7:0] mref [256];   // bench's own expectation of the file
  logic [7:0] m_addr;
  logic [3:0] m_hold;

  logic [23:0] wq [$];      // {tag, addr, data}
  logic [15:0] rq [$];      // {tag, data}

  always #(CLK_PERIOD/2) clk = ~clk;

  nibreg_slave u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_byte  (cmd_byte),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .wr_stb    (wr_stb),
    .wr_sel    (wr_sel),
    .wr_byte   (wr_byte),
    .ret_valid (ret_valid),
    .ret_byte  (ret_byte)
  );

  assign reg_rdata = regs[reg_sel];

  always @(posedge clk) if (wr_stb) regs[wr_sel] <= wr_byte;

  function automatic logic [7:0] seed_val(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: updates the reference model, queues expectations, drives one byte.
  task automatic send(input logic [7:0] b, input logic [7:0] tag_rd);
    logic [3:0] op;
    logic [3:0] p;
    op = b[7:4];
    p  = b[3:0];
    case (op)
      4'h0: m_addr[3:0] = p;
      4'h1: m_addr[7:4] = p;
      4'h2: m_hold = p;
      4'h3: begin
        wq.push_back({8'd5, m_addr, p, m_hold});
        mref[m_addr] = {p, m_hold};
        m_addr = m_addr + 8'd1;
      end
      4'h4: rq.push_back({8'd7, mref[m_addr]});
      4'h5: begin
        rq.push_back({tag_rd, mref[m_addr]});
        m_addr = m_addr + 8'd1;
      end
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_addr(input string req);
    check(req, 32'(reg_sel), 32'(m_addr));
  endtask

  // Monitor: compares every strobe and returned byte against the queues.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        if (wq.size() == 0) check("R5 unexpected strobe", 32'(wr_sel), 32'hFFFF);
        else begin
          logic [23:0] e;
          e = wq.pop_front();
          check($sformatf("R%0d write", e[23:16]), {16'h0, wr_sel, wr_byte}, {16'h0, e[15:0]});
        end
      end
      if (ret_valid) begin
        if (rq.size() == 0) check("R7 unexpected return", 32'(ret_byte), 32'hFFFF);
        else begin
          logic [15:0] e;
          e = rq.pop_front();
          check($sformatf("R%0d read", e[15:8]), 32'(ret_byte), 32'(e[7:0]));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 256; i++) begin
      regs[i] = seed_val(i);
      mref[i] = seed_val(i);
    end
    m_addr = 8'h00;
    m_hold = 4'h0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(cmd_ready), 0);
    check("R1 strobe in reset", 32'(wr_stb), 0);
    check("R1 return in reset", 32'(ret_valid), 0);
    check("R1 addr in reset", 32'(reg_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(cmd_ready), 1);

    // R1/R5: held nibble is zero after reset, write at address 0
    send(8'h3A, 8'd8);
    idle(2);
    chk_addr("R6 bump after first write");

    // R2, R3: address nibble loads
    send(8'h0C, 8'd8); send(8'h15, 8'd8);
    idle(1);
    chk_addr("R3 address 5C");
    send(8'h07, 8'd8);
    idle(1);
    chk_addr("R2 low nibble only");

    // R4, R5, R6: burst of three bytes from 0x57
    send(8'h21, 8'd8); send(8'h32, 8'd8);
    send(8'h23, 8'd8); send(8'h34, 8'd8);
    send(8'h25, 8'd8); send(8'h36, 8'd8);
    idle(2);
    chk_addr("R6 burst end 5A");

    // R11: held nibble reused
    send(8'h39, 8'd8);
    idle(2);

    // R4: low nibble alone writes nothing (monitor flags stray strobe)
    send(8'h2E, 8'd8);
    idle(2);
    chk_addr("R4 no bump on low data");

    // R6: wrap from FF
    send(8'h0F, 8'd8); send(8'h1F, 8'd8);
    send(8'h20, 8'd8); send(8'h31, 8'd8);
    idle(2);
    chk_addr("R6 wrap to 00");

    // R7: plain reads keep address
    send(8'h08, 8'd8); send(8'h15, 8'd8);
    send(8'h40, 8'd8); send(8'h40, 8'd8);
    idle(2);
    chk_addr("R7 address held");

    // R8: six read-next commands over a block
    send(8'h00, 8'd8); send(8'h11, 8'd8);
    for (int k = 0; k < 6; k++) send(8'h50, 8'd8);
    idle(2);
    chk_addr("R8 address advanced by six");

    // R9: unknown opcodes
    send(8'h6F, 8'd8); send(8'h8A, 8'd8); send(8'hF3, 8'd8); send(8'hC1, 8'd8);
    idle(2);
    chk_addr("R9 address unchanged");

    // R10: bytes without valid
    @(negedge clk);
    cmd_valid = 1'b0; cmd_byte = 8'h3F;
    @(negedge clk); cmd_byte = 8'h0F;
    @(negedge clk); cmd_byte = 8'h50;
    idle(2);
    chk_addr("R10 address unchanged");

    // R8: read back written burst
    send(8'h07, 8'd8); send(8'h15, 8'd8);
    send(8'h50, 8'd8); send(8'h50, 8'd8); send(8'h50, 8'd8); send(8'h50, 8'd8);
    idle(2);

    // mixed pseudo-random command stream
    lf = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send({1'b0, lf[6:0]}, 8'd8);
    end
    idle(3);
    chk_addr("R2 address after mixed stream");
    check("R5 pending writes", 32'(wq.size()), 0);
    check("R7 pending reads", 32'(rq.size()), 0);
    finish_run();
  end

endmodule